// File: doc/BRIEF.md
# Dual-Channel Memory Fill Engine

This block writes a constant pattern over a range of byte addresses. It has two fill channels that work independently. Each channel holds a start address, an end address, a fill value and a control word, and software sets them through a small register write port. A fill begins only when the channel's control register is written with its go bit set. The channel then steps through memory, one write per grant, from the start address up to the end address, with the end address excluded. Each step is one beat on a shared byte-enabled memory write port.

A step writes a 16-bit halfword, a 24-bit colour triplet or a 32-bit word, as chosen by two width flags in the control word. When both channels have writes pending, a round-robin arbiter lets them take turns on the write port. When a channel finishes, it drops its busy indication, sets its finished flag and raises a one-cycle pulse on its own interrupt line. A channel whose start address is zero goes through the same handshake but writes no memory and raises no interrupt.

Top module: `memfill_dual`

## Requirements
- R1: A channel starts only when its control register (`reg_sel` = 3) is written with bit 0 set. Writes to start (`reg_sel` = 0), end (1) or value (2), and control writes with bit 0 clear, never start a fill.
- R2: When control bit 2 is set and bit 1 is clear, each step writes `mem_be` = 4'b1111 with `mem_wdata` equal to the fill value, and the address then advances by 4.
- R3: When control bits 1 and 2 are both clear, each step writes `mem_be` = 4'b0011 with `mem_wdata[15:0]` equal to the fill value bits [15:0] and the upper bits zero. The address then advances by 2.
- R4: When control bit 1 is set, each step writes three bytes with `mem_be` = 4'b0111. Byte lane 0 carries red (value[23:16]), lane 1 carries green (value[15:8]) and lane 2 carries blue (value[7:0]). The address advances by 3. Bit 1 takes priority over bit 2.
- R5: The first write goes to the start address. A step is issued for every step address below the end address, and such a step is written in full even when it reaches past the end address. No write occurs at or above the end address.
- R6: After a channel's last write, the channel clears busy, sets its finished flag and pulses its own bit of `irq` for exactly one cycle. This all happens in the cycle after its final write is presented.
- R7: A go write to a channel whose start address is zero issues no memory write and no interrupt. One cycle later the finished flag is set and busy stays low.
- R8: While both channels have writes pending, consecutive writes on the port alternate between the channels.
- R9: A go write to a channel that is busy is ignored. The running fill continues with its original range and pattern.
- R10: A go write clears the channel's finished flag for as long as the new fill runs. Busy and finished are never high together.
- R11: After reset, busy, finished, `irq` and `mem_wr_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_ch | input | 1 | Channel selected by the register write |
| reg_sel | input | 2 | Register: 0 start, 1 end, 2 value, 3 control |
| reg_wdata | input | 32 | Register write data (control: bit 0 go, bit 1 24-bit, bit 2 32-bit) |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | AW | Byte address of lane 0 |
| mem_wdata | output | 32 | Write data, lane 0 in bits [7:0] |
| mem_be | output | 4 | Byte lane enables |
| busy | output | 2 | Per-channel fill in progress (the go bit) |
| done | output | 2 | Per-channel finished flag |
| irq | output | 2 | Per-channel completion pulse |

## Verification
A go write that is sampled at clock edge E loads the channel at E. The first write of that channel appears on the port after edge E+1. Each later write appears one edge after the grant that produced it. A lone channel therefore shows its N writes after edges E+1 through E+N, and its `irq` pulse together with the finished flag after edge E+N+1. The bench drives its inputs on falling edges and samples every output on falling edges. It keeps a queue of expected writes for each channel, matches each write to the head of a queue in the cycle it appears, and counts an `irq` pulse as valid only when the queue for that channel has already emptied.

// File: rtl/memfill_pkg.sv
package memfill_pkg;
  localparam int NCH = 2;
  localparam int DW  = 32;
  localparam int BEW = DW / 8;

  typedef enum logic [1:0] {SEL_START = 2'd0, SEL_END = 2'd1, SEL_VALUE = 2'd2, SEL_CTRL = 2'd3} reg_sel_e;
  typedef enum logic [1:0] {PAT16 = 2'd0, PAT24 = 2'd1, PAT32 = 2'd2} pat_e;

  // triplet flag wins over word flag
  function automatic pat_e decode_pat(input logic f24, input logic f32);
    if (f24)      return PAT24;
    else if (f32) return PAT32;
    else          return PAT16;
  endfunction

  function automatic logic [2:0] step_of(input pat_e p);
    case (p)
      PAT24:   return 3'd3;
      PAT32:   return 3'd4;
      default: return 3'd2;
    endcase
  endfunction

  function automatic logic [BEW-1:0] be_of(input pat_e p);
    case (p)
      PAT24:   return 4'b0111;
      PAT32:   return 4'b1111;
      default: return 4'b0011;
    endcase
  endfunction

  function automatic logic [DW-1:0] data_of(input pat_e p, input logic [DW-1:0] v);
    case (p)
      PAT24:   return {8'h00, v[7:0], v[15:8], v[23:16]};
      PAT32:   return v;
      default: return {16'h0000, v[15:0]};
    endcase
  endfunction
endpackage

// File: rtl/memfill_chan.sv
module memfill_chan
  import memfill_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [1:0]     sel,
  input  logic [DW-1:0]  wdata,
  input  logic           gnt,
  output logic           req,
  output logic [AW-1:0]  wr_addr,
  output logic [DW-1:0]  wr_data,
  output logic [BEW-1:0] wr_be,
  output logic           busy,
  output logic           done,
  output logic           irq
);
  logic [AW-1:0] start_q, end_q, lim_q;
  logic [DW-1:0] value_q, fill_q;
  logic [AW:0]   cur_q;
  pat_e          pat_q;
  logic          at_end;

  assign at_end  = !(cur_q < {1'b0, lim_q});
  assign req     = busy && !at_end;
  assign wr_addr = cur_q[AW-1:0];
  assign wr_data = data_of(pat_q, fill_q);
  assign wr_be   = be_of(pat_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      end_q   <= '0;
      lim_q   <= '0;
      value_q <= '0;
      fill_q  <= '0;
      cur_q   <= '0;
      pat_q   <= PAT16;
      busy    <= 1'b0;
      done    <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (wr_en) begin
        case (reg_sel_e'(sel))
          SEL_START: start_q <= wdata[AW-1:0];
          SEL_END:   end_q   <= wdata[AW-1:0];
          SEL_VALUE: value_q <= wdata;
          default: begin
            if (wdata[0] && !busy) begin
              pat_q  <= decode_pat(wdata[1], wdata[2]);
              fill_q <= value_q;
              lim_q  <= end_q;
              cur_q  <= {1'b0, start_q};
              if (start_q == '0) begin
                done <= 1'b1;
              end else begin
                busy <= 1'b1;
                done <= 1'b0;
              end
            end
          end
        endcase
      end
      if (busy) begin
        if (gnt) begin
          cur_q <= cur_q + (AW+1)'(step_of(pat_q));
        end else if (at_end) begin
          busy <= 1'b0;
          done <= 1'b1;
          irq  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/memfill_arb.sv
module memfill_arb
  import memfill_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NCH-1:0]           req,
  input  logic [NCH-1:0][AW-1:0]   addr_i,
  input  logic [NCH-1:0][DW-1:0]   data_i,
  input  logic [NCH-1:0][BEW-1:0]  be_i,
  output logic [NCH-1:0]           gnt,
  output logic                     mem_wr_en,
  output logic [AW-1:0]            mem_addr,
  output logic [DW-1:0]            mem_wdata,
  output logic [BEW-1:0]           mem_be
);
  logic last_q;

  always_comb begin
    if (&req) gnt = last_q ? 2'b01 : 2'b10;
    else      gnt = req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q    <= 1'b0;
      mem_wr_en <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_be    <= '0;
    end else begin
      mem_wr_en <= |gnt;
      if (|gnt) begin
        last_q    <= gnt[1];
        mem_addr  <= gnt[1] ? addr_i[1] : addr_i[0];
        mem_wdata <= gnt[1] ? data_i[1] : data_i[0];
        mem_be    <= gnt[1] ? be_i[1]   : be_i[0];
      end
    end
  end
endmodule

// File: rtl/memfill_dual.sv
module memfill_dual
  import memfill_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wr_en,
  input  logic           reg_ch,
  input  logic [1:0]     reg_sel,
  input  logic [31:0]    reg_wdata,
  output logic           mem_wr_en,
  output logic [AW-1:0]  mem_addr,
  output logic [31:0]    mem_wdata,
  output logic [3:0]     mem_be,
  output logic [1:0]     busy,
  output logic [1:0]     done,
  output logic [1:0]     irq
);
  logic [NCH-1:0]          req, gnt;
  logic [NCH-1:0][AW-1:0]  ch_addr;
  logic [NCH-1:0][DW-1:0]  ch_data;
  logic [NCH-1:0][BEW-1:0] ch_be;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    memfill_chan #(.AW(AW)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (reg_wr_en && (reg_ch == 1'(i))),
      .sel     (reg_sel),
      .wdata   (reg_wdata),
      .gnt     (gnt[i]),
      .req     (req[i]),
      .wr_addr (ch_addr[i]),
      .wr_data (ch_data[i]),
      .wr_be   (ch_be[i]),
      .busy    (busy[i]),
      .done    (done[i]),
      .irq     (irq[i])
    );
  end

  memfill_arb #(.AW(AW)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .addr_i    (ch_addr),
    .data_i    (ch_data),
    .be_i      (ch_be),
    .gnt       (gnt),
    .mem_wr_en (mem_wr_en),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_be    (mem_be)
  );
endmodule

// File: rtl/memfill_chk.sv
module memfill_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr_en,
  input logic       reg_ch,
  input logic [1:0] reg_sel,
  input logic       reg_go,
  input logic       mem_wr_en,
  input logic [3:0] mem_be,
  input logic [1:0] busy,
  input logic [1:0] done,
  input logic [1:0] irq
);
  for (genvar i = 0; i < 2; i++) begin : g_c
    // R1
    start_src_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(busy[i]) |-> $past(reg_wr_en && reg_go && reg_sel == 2'd3 && reg_ch == 1'(i)));
    // R6
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      irq[i] |=> !irq[i]);
    // R6
    irq_state_chk: assert property (@(posedge clk) disable iff (rst)
      irq[i] |-> (done[i] && !busy[i]));
    // R10
    busy_done_chk: assert property (@(posedge clk) disable iff (rst)
      busy[i] |-> !done[i]);
  end
  // R2 R3 R4
  lane_mask_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> (mem_be == 4'b0011 || mem_be == 4'b0111 || mem_be == 4'b1111));
endmodule

bind memfill_dual memfill_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr_en (reg_wr_en),
  .reg_ch    (reg_ch),
  .reg_sel   (reg_sel),
  .reg_go    (reg_wdata[0]),
  .mem_wr_en (mem_wr_en),
  .mem_be    (mem_be),
  .busy      (busy),
  .done      (done),
  .irq       (irq)
);

// File: tb/tb_memfill_dual.sv
module tb_memfill_dual;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr_en = 1'b0;
  logic          reg_ch = 1'b0;
  logic [1:0]    reg_sel = 2'd0;
  logic [31:0]   reg_wdata = '0;
  logic          mem_wr_en;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [3:0]    mem_be;
  logic [1:0]    busy, done, irq;

  always #5 clk = ~clk;

  memfill_dual #(.AW(AW)) dut (.*);

  typedef struct {
    logic [AW-1:0] addr;
    logic [31:0]   data;
    logic [3:0]    be;
    string         tag;
  } wr_t;

  wr_t q0[$];
  wr_t q1[$];
  int  n_run = 0;
  int  n_fail = 0;
  int  irq_cnt [2] = '{0, 0};
  bit  alt_mode = 0;
  int  last_ch = -1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input int ch, input int sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_ch = ch[0]; reg_sel = sel[1:0]; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  // driver: build the expected writes of one fill, then trigger it
  task automatic launch(input int ch, input int st, input int en, input logic [31:0] v,
                        input logic [2:0] mode);
    int step; logic [3:0] be; logic [31:0] d; string tg;
    if (mode[1])      begin step = 3; be = 4'b0111; d = {8'h0, v[7:0], v[15:8], v[23:16]}; tg = "R4"; end
    else if (mode[2]) begin step = 4; be = 4'b1111; d = v; tg = "R2"; end
    else              begin step = 2; be = 4'b0011; d = {16'h0, v[15:0]}; tg = "R3"; end
    if (st != 0) begin
      for (int a = st; a < en; a += step) begin
        wr_t w; w.addr = AW'(a); w.data = d; w.be = be; w.tag = tg;
        if (ch == 0) q0.push_back(w); else q1.push_back(w);
      end
    end
    reg_wr(ch, 0, st);
    reg_wr(ch, 1, en);
    reg_wr(ch, 2, v);
    reg_wr(ch, 3, {29'd0, mode});
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy != 2'b00) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_wr_en) begin
        int ch = -1; wr_t w;
        if (q0.size() > 0 && q0[0].addr == mem_addr) begin ch = 0; w = q0.pop_front(); end
        else if (q1.size() > 0 && q1[0].addr == mem_addr) begin ch = 1; w = q1.pop_front(); end
        chk(ch >= 0, "R5 unexpected write address", mem_addr, q0.size() ? q0[0].addr : 0);
        if (ch >= 0) begin
          chk(mem_wdata == w.data, {w.tag, " data"}, mem_wdata, w.data);
          chk(mem_be == w.be, {w.tag, " byte enables"}, mem_be, w.be);
          if (alt_mode && last_ch >= 0)
            chk(ch != last_ch, "R8 alternation", ch, 1 - last_ch);
          last_ch = ch;
        end
      end
      for (int i = 0; i < 2; i++) begin
        if (irq[i]) begin
          irq_cnt[i]++;
          chk((i == 0 ? q0.size() : q1.size()) == 0, "R6 irq after last write",
              i == 0 ? q0.size() : q1.size(), 0);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(busy == 0 && done == 0 && irq == 0 && mem_wr_en == 0, "R11 reset outputs",
        {busy, done, irq, mem_wr_en}, 0);

    // R1: non-trigger writes do not start
    reg_wr(0, 0, 32'h0601);
    reg_wr(0, 1, 32'h0621);
    reg_wr(0, 2, 32'h0000_0001);
    reg_wr(0, 3, 32'h0000_0004);
    repeat (6) @(negedge clk);
    chk(busy == 0 && done == 0, "R1 no start without go bit", {busy, done}, 0);

    // R2 32-bit fill, R6 completion
    launch(0, 16'h0100, 16'h0110, 32'hDEAD_BEEF, 3'b101);
    wait_idle();
    chk(q0.size() == 0, "R2 all writes seen", q0.size(), 0);
    chk(done[0] == 1'b1 && busy[0] == 1'b0, "R6 finished flag", {busy[0], done[0]}, 1);
    chk(irq_cnt[0] == 1, "R6 irq count", irq_cnt[0], 1);

    // R3 16-bit fill on channel 1
    launch(1, 16'h0200, 16'h0206, 32'h1234_5678, 3'b001);
    wait_idle();
    chk(q1.size() == 0 && irq_cnt[1] == 1, "R3 fill complete", irq_cnt[1], 1);

    // R4 24-bit with both width flags, R10 finished cleared on restart
    launch(0, 16'h0300, 16'h0309, 32'h00A1_B2C3, 3'b111);
    @(negedge clk);
    chk(done[0] == 1'b0, "R10 finished cleared while running", done[0], 0);
    wait_idle();
    chk(q0.size() == 0 && irq_cnt[0] == 2, "R4 fill complete", irq_cnt[0], 2);

    // R5 partial last step
    launch(0, 16'h0400, 16'h0405, 32'hCAFE_F00D, 3'b101);
    wait_idle();
    chk(q0.size() == 0 && irq_cnt[0] == 3, "R5 partial step written", irq_cnt[0], 3);

    // R7 zero start
    launch(1, 0, 16'h0010, 32'h5555_5555, 3'b101);
    wait_idle();
    chk(irq_cnt[1] == 1, "R7 no interrupt", irq_cnt[1], 1);
    chk(done[1] == 1'b1 && busy[1] == 1'b0, "R7 finished set", {busy[1], done[1]}, 1);

    // R8 concurrent fills alternate
    reg_wr(0, 0, 16'h0700); reg_wr(0, 1, 16'h0710); reg_wr(0, 2, 32'h0A0A_0A0A);
    reg_wr(1, 0, 16'h0800); reg_wr(1, 1, 16'h0808); reg_wr(1, 2, 32'h0000_B0B0);
    for (int a = 16'h0700; a < 16'h0710; a += 4) begin
      wr_t w; w.addr = AW'(a); w.data = 32'h0A0A_0A0A; w.be = 4'b1111; w.tag = "R8"; q0.push_back(w);
    end
    for (int a = 16'h0800; a < 16'h0808; a += 2) begin
      wr_t w; w.addr = AW'(a); w.data = 32'h0000_B0B0; w.be = 4'b0011; w.tag = "R8"; q1.push_back(w);
    end
    alt_mode = 1; last_ch = -1;
    @(negedge clk);
    reg_wr_en = 1'b1; reg_ch = 1'b0; reg_sel = 2'd3; reg_wdata = 32'h5;
    @(negedge clk);
    reg_ch = 1'b1; reg_wdata = 32'h1;
    @(negedge clk);
    reg_wr_en = 1'b0;
    wait_idle();
    alt_mode = 0;
    chk(q0.size() == 0 && q1.size() == 0, "R8 both fills complete", q0.size() + q1.size(), 0);
    chk(irq_cnt[0] == 4 && irq_cnt[1] == 2, "R6 separate irq lines", {irq_cnt[0], irq_cnt[1]}, {4, 2});

    // R9 go write while busy is ignored
    launch(0, 16'h0900, 16'h0920, 32'h7777_1111, 3'b101);
    reg_wr(0, 3, 32'h0000_0003);
    wait_idle();
    chk(q0.size() == 0 && irq_cnt[0] == 5, "R9 running fill unchanged", irq_cnt[0], 5);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule